// File: doc/BRIEF.md
# ADC Conversion and Serial Readout Sequencer

The sequencer is the serial master for a dual-channel 16-bit sampling converter. A free-running timer produces a tick every `TIMER_PERIOD` system clocks. Each tick that finds the block idle starts a conversion by driving a convert-start pulse. The converter raises its busy line while it converts. The sequencer synchronizes that line and waits for it to fall. It then lowers chip select and clocks in the 32-bit result as two back-to-back 16-bit words. The serial clock idles low, and data is captured on the falling (second) edge of each bit.

The two words are joined into one 32-bit result, with the first word in the upper half. The result is offered on a valid/ready output. A tick that arrives while a conversion, a readout, the chip-select gap or an unaccepted result is still pending is dropped. Such a tick sets a sticky overrun flag, which only reset clears. The serial clock is the system clock divided by `SCLK_DIV`. That divisor must keep the serial clock at or below 17 MHz.

Top module: `adc_seq`

## Requirements
- R1: A timer tick occurs on every `TIMER_PERIOD`-th system clock after reset, the first one `TIMER_PERIOD` cycles after reset release. A tick that finds the block idle drives `cnv_o` high for exactly `CNV_W` cycles, starting on the next clock.
- R2: Chip select is low only after the synchronized busy input has fallen. It is never low while `busy_i` is high or while `cnv_o` is high.
- R3: One readout is a single chip-select-low window holding exactly 32 serial clock cycles, which are two 16-bit words with no gap between them.
- R4: The serial clock is low whenever chip select is high. The converter changes data on the rising edge, and `sdi_i` is captured on the falling edge.
- R5: Each serial clock half period lasts `SCLK_DIV/2` system clocks, so the serial clock never exceeds 17 MHz.
- R6: `data_o` holds the first received word in bits [31:16] and the second in bits [15:0]. Each word is received most significant bit first.
- R7: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `data_o` stays unchanged. A result is consumed on a clock edge with both high.
- R8: After the last bit, chip select stays high for at least `CS_GAP` (default 2) system clocks.
- R9: A tick that arrives while the block is not idle starts no conversion and sets `overrun_o`. `overrun_o` stays set until reset.
- R10: During reset, `cs_no` is 1, `sclk_o` is 0, `cnv_o` is 0, `valid_o` is 0 and `overrun_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_o | output | 1 | Convert-start pulse to the converter |
| busy_i | input | 1 | Converter busy, asynchronous |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data from the converter |
| data_o | output | 2*WORD_W | Result, first word in the upper half |
| valid_o | output | 1 | Result valid |
| ready_i | input | 1 | Consumer ready |
| overrun_o | output | 1 | Sticky dropped-tick flag |

## Verification
A wrong sequencer state appears at the ports within a cycle or two. A stuck or misordered state either drives `cnv_o` outside its expected window or leaves the next tick dropped, and the overrun comparison then flags it at once. A miscounting shifter or divider shows up when its chip-select window closes, as a wrong clock count or a wrong high-phase length. It also shows up when the result is accepted, as a bit-shifted or word-swapped value against the value the converter model served. A broken hold on the output is caught on the cycle after the consumer stalls.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned MAX_SCLK_HZ = 17_000_000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_READ,
    ST_GAP,
    ST_DRAIN
  } seq_state_e;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(PERIOD);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = last_q & ~level_o;
endmodule

// File: rtl/adc_seq_spi.sv
module adc_seq_spi import adc_seq_pkg::*; #(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned SCLK_DIV = 12,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned WORDS    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      sdi_i,
  output logic                      sclk_o,
  output logic                      cs_no,
  output logic                      done_o,
  output logic [WORD_W*WORDS-1:0]   data_o
);
  localparam int unsigned FRAME_W = WORD_W * WORDS;
  localparam int unsigned HALF    = SCLK_DIV / 2;
  localparam int unsigned DW      = $clog2(HALF) + 1;
  localparam int unsigned BW      = $clog2(FRAME_W) + 1;

  logic               active_q;
  logic [DW-1:0]      div_q;
  logic [BW-1:0]      bit_q;
  logic               sclk_q;
  logic               done_q;
  logic [FRAME_W-1:0] shift_q;
  logic               edge_w;

  assign edge_w = active_q && (div_q == DW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      shift_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        div_q    <= '0;
        bit_q    <= '0;
        sclk_q   <= 1'b0;
      end else if (active_q) begin
        if (edge_w) begin
          div_q  <= '0;
          sclk_q <= ~sclk_q;
          // falling edge: capture, slave shifted on the rising one
          if (sclk_q) begin
            shift_q <= {shift_q[FRAME_W-2:0], sdi_i};
            if (bit_q == BW'(FRAME_W - 1)) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign cs_no  = ~active_q;
  assign done_o = done_q;
  assign data_o = shift_q;

  // rate monitor for the serial clock
  logic        sclk_d;
  logic        seen_q;
  logic [15:0] per_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      seen_q <= 1'b0;
      per_q  <= '0;
    end else begin
      sclk_d <= sclk_q;
      if (!active_q) begin
        seen_q <= 1'b0;
        per_q  <= '0;
      end else if (sclk_q && !sclk_d) begin
        seen_q <= 1'b1;
        per_q  <= '0;
      end else if (per_q != 16'hFFFF) begin
        per_q <= per_q + 1'b1;
      end
    end
  end

  // R5
  sclk_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && !sclk_d && seen_q) |->
      (longint'(CLK_HZ) <= longint'(MAX_SCLK_HZ) * (longint'(per_q) + 1)));

  // R4
  sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  // R3
  cs_release_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_no);
endmodule

// File: rtl/adc_seq.sv
module adc_seq import adc_seq_pkg::*; #(
  parameter int unsigned CLK_HZ       = 200_000_000,
  parameter int unsigned SCLK_DIV     = 12,
  parameter int unsigned TIMER_PERIOD = 1000,
  parameter int unsigned CNV_W        = 4,
  parameter int unsigned CS_GAP       = 2,
  parameter int unsigned WORD_W       = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic                  cnv_o,
  input  logic                  busy_i,
  output logic                  cs_no,
  output logic                  sclk_o,
  input  logic                  sdi_i,
  output logic [2*WORD_W-1:0]   data_o,
  output logic                  valid_o,
  input  logic                  ready_i,
  output logic                  overrun_o
);
  localparam int unsigned FRAME_W  = 2 * WORD_W;
  localparam int unsigned HOLD_MAX = (CNV_W > CS_GAP) ? CNV_W : CS_GAP;
  localparam int unsigned HW       = $clog2(HOLD_MAX + 1);

  logic               tick_w;
  logic               busy_lvl_w;
  logic               busy_fall_w;
  logic               spi_done_w;
  logic [FRAME_W-1:0] spi_data_w;

  seq_state_e         state_q;
  logic [HW-1:0]      hold_q;
  logic               cnv_q;
  logic               start_q;
  logic               valid_q;
  logic [FRAME_W-1:0] data_q;
  logic               ovr_q;

  adc_seq_timer #(.PERIOD(TIMER_PERIOD)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick_w)
  );

  adc_seq_sync #(.STAGES(2)) busy_sync_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (busy_i),
    .level_o (busy_lvl_w),
    .fall_o  (busy_fall_w)
  );

  adc_seq_spi #(
    .CLK_HZ   (CLK_HZ),
    .SCLK_DIV (SCLK_DIV),
    .WORD_W   (WORD_W),
    .WORDS    (2)
  ) spi_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_q),
    .sdi_i   (sdi_i),
    .sclk_o  (sclk_o),
    .cs_no   (cs_no),
    .done_o  (spi_done_w),
    .data_o  (spi_data_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      cnv_q   <= 1'b0;
      start_q <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (tick_w && state_q != ST_IDLE) ovr_q <= 1'b1;
      if (valid_q && ready_i) valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (tick_w) begin
          state_q <= ST_CONV;
          cnv_q   <= 1'b1;
          hold_q  <= '0;
        end
        ST_CONV: if (hold_q == HW'(CNV_W - 1)) begin
          cnv_q   <= 1'b0;
          state_q <= ST_WAIT;
        end else begin
          hold_q <= hold_q + 1'b1;
        end
        ST_WAIT: if (busy_fall_w) begin
          start_q <= 1'b1;
          state_q <= ST_READ;
        end
        ST_READ: if (spi_done_w) begin
          data_q  <= spi_data_w;
          valid_q <= 1'b1;
          hold_q  <= '0;
          state_q <= ST_GAP;
        end
        ST_GAP: if (hold_q == HW'(CS_GAP - 1)) state_q <= ST_DRAIN;
                else hold_q <= hold_q + 1'b1;
        ST_DRAIN: if (!valid_q) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o     = cnv_q;
  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign overrun_o = ovr_q;

  // R1
  cnv_from_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> $past(tick_w));

  // R2
  read_after_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> (!busy_lvl_w && !cnv_o));

  // R7
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  // R8
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: tb/adc_seq_tb_top.sv
`timescale 1ns/1ps
module adc_seq_tb_top;
  localparam int P      = 1000;
  localparam int HALF   = 6;
  localparam int CNVW   = 4;
  localparam int GAP    = 2;
  localparam int BUSY_T = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv, busy, cs_n, sclk, sdo, valid, ready, ovr;
  logic [31:0] data;

  always #2.5 clk = ~clk;

  adc_seq dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cnv_o     (cnv),
    .busy_i    (busy),
    .cs_no     (cs_n),
    .sclk_o    (sclk),
    .sdi_i     (sdo),
    .data_o    (data),
    .valid_o   (valid),
    .ready_i   (ready),
    .overrun_o (ovr)
  );

  int n_cmp = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] val_of(input int n);
    case (n)
      0: val_of = 32'hFFFF_0000;
      1: val_of = 32'h0000_FFFF;
      2: val_of = 32'h8000_0001;
      3: val_of = 32'h0000_0000;
      4: val_of = 32'hFFFF_FFFF;
      default: val_of = (32'(n) * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endcase
  endfunction

  // converter model
  logic [31:0] exp_q[$];
  logic [31:0] cur_val = '0;
  logic [31:0] sh = '0;
  int conv_n = 0;
  int bcnt = 0;
  logic cnv_prev = 1'b0;

  initial begin
    busy = 1'b0;
    sdo  = 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      cyc <= cyc + 1;
      cnv_prev <= cnv;
      if (cnv && !cnv_prev) begin
        busy    <= 1'b1;
        bcnt    <= BUSY_T;
        cur_val <= val_of(conv_n);
        exp_q.push_back(val_of(conv_n));
        conv_n  <= conv_n + 1;
      end else if (bcnt > 0) begin
        bcnt <= bcnt - 1;
        if (bcnt == 1) busy <= 1'b0;
      end
    end
  end

  always @(negedge cs_n) sh = cur_val;
  always @(posedge sclk) if (!cs_n) begin
    sdo <= sh[31];
    sh = sh << 1;
  end

  // reference model, compared every clock
  bit eng = 1'b0, ovr_exp = 1'b0, read_done = 1'b0;
  int cnv_left = 0, gap_samp = 100, hi_run = 0, rises = 0, handshakes = 0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_valid = 1'b0, prev_ready = 1'b1;
  logic [31:0] prev_data = '0;

  always @(negedge clk) if (rst_n && !finished) begin
    if (cyc > 0 && cyc % P == 0) begin
      if (!eng) begin eng = 1'b1; cnv_left = CNVW; read_done = 1'b0; end
      else ovr_exp = 1'b1;
    end
    chk(cnv === (cnv_left > 0), "R1", "cnv_o", longint'(cnv), longint'(cnv_left > 0));
    if (cnv_left > 0) cnv_left--;
    chk(ovr === ovr_exp, "R9", "overrun_o", longint'(ovr), longint'(ovr_exp));
    if (cs_n === 1'b0)
      chk(!busy && !cnv, "R2", "busy/cnv while cs low", longint'({busy, cnv}), 0);
    if (cs_n === 1'b1)
      chk(sclk === 1'b0, "R4", "sclk idle", longint'(sclk), 0);
    if (sclk) hi_run++;
    if (prev_sclk && !sclk) begin
      chk(hi_run == HALF, "R5", "sclk high phase", hi_run, HALF);
      hi_run = 0;
    end
    if (!prev_sclk && sclk) rises++;
    if (prev_cs && !cs_n) begin
      chk(gap_samp >= GAP, "R8", "cs high gap", gap_samp, GAP);
      rises = 0;
    end
    if (!prev_cs && cs_n) begin
      chk(rises == 32, "R3", "sclk cycles per frame", rises, 32);
      read_done = 1'b1;
      gap_samp = 0;
    end
    if (cs_n) gap_samp++;
    if (prev_valid && !prev_ready)
      chk(valid && data == prev_data, "R7", "held result",
          longint'({valid, data}), longint'({1'b1, prev_data}));
    if (valid && ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected result", longint'(data), 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(data === e, "R6", "result word order", longint'(data), longint'(e));
      end
      handshakes++;
    end
    if (eng && read_done && cs_n && !valid && gap_samp > GAP + 1) eng = 1'b0;
    prev_sclk = sclk; prev_cs = cs_n; prev_valid = valid;
    prev_ready = ready; prev_data = data;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  initial begin
    ready = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cs_n === 1'b1, "R10", "cs_no", longint'(cs_n), 1);
    chk(sclk === 1'b0, "R10", "sclk_o", longint'(sclk), 0);
    chk(cnv === 1'b0, "R10", "cnv_o", longint'(cnv), 0);
    chk(valid === 1'b0, "R10", "valid_o", longint'(valid), 0);
    chk(ovr === 1'b0, "R10", "overrun_o", longint'(ovr), 0);
    rst_n = 1'b1;
    while (cyc < 4100) @(posedge clk);
    #1 ready = 1'b0;   // stall consumer across the 5000 tick
    while (cyc < 5300) @(posedge clk);
    #1 ready = 1'b1;
    while (cyc < 9800) @(posedge clk);
    @(negedge clk);
    chk(handshakes == 8, "R9", "accepted conversions", handshakes, 8);
    chk(exp_q.size() == 0, "R6", "results outstanding", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    #80us;
    chk(1'b0, "R1", "watchdog expired", cyc, 9800);
    finish_run();
  end
endmodule